// File: doc/BRIEF.md
# Microcode Step Sequencer with Ready Stall

This block produces the step number that a microcoded instruction decoder uses to walk an opcode through its micro-steps. The step value is five bits wide. Its lowest bit is the current clock phase, which is modelled here as a register that toggles on each system clock. Its upper four bits are a binary counter. That counter advances once for each full phase cycle, at the moment the high phase ends.

The microcode requests a clear of the step on the last step of an instruction, and the counter then restarts at zero. Each time the step equals one, the block raises a load strobe. The opcode on the data input is then copied into an instruction register, which holds it for the rest of the instruction. A sync output marks the first cycle of each opcode.

A ready input that is low at the end of a high phase freezes the sequencer. It stays on that odd step until ready is seen high again, so no half-step is lost.

Top module: `ustep_seq`

## Requirements
- R1: The step output is {counter, phase}. After a cycle with phase 0, the next cycle has phase 1 and an unchanged counter, whatever the ready and clear inputs are.
- R2: After a cycle with phase 1, ready high and clear low, the next cycle has phase 0 and the counter plus one. The counter wraps from 15 to 0.
- R3: After a cycle with phase 1, ready high and clear high, the step is 0.
- R4: A clear request seen in a cycle with phase 0, or during a stalled cycle, has no effect on the step.
- R5: While rst_n is low, the step is 0 and the instruction register is 0. Both stay there for as long as reset is held.
- R6: After a cycle with phase 1 and ready low, the step is unchanged. The sequencer resumes on the first edge where ready is high. Ready low during phase 0 has no effect.
- R7: ir_load is 1 exactly when the step is 1 (counter 0, phase 1).
- R8: On every clock edge where ir_load is 1, the instruction register takes din. At all other edges it keeps its value.
- R9: sync is 1 exactly when the counter bits are zero, which means steps 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy | input | 1 | Ready; when low at the end of a high phase, the sequencer stalls |
| clr_step | input | 1 | Clear request from the microcode, taken at the end of a high phase |
| din | input | 8 | Opcode from the data bus |
| step | output | 5 | Step number {counter, phase} |
| ir_load | output | 1 | Instruction register load strobe at step 1 |
| sync | output | 1 | First-cycle indication of an opcode |
| ir | output | 8 | Instruction register |

## Verification
The bench runs instructions of 2, 4 and 7 full cycles. In these runs the clear request is held high across the low phase of the final count, so a design that cleared early would cut every instruction short. Stalls of 0, 1 and 5 cycles are placed on step 3. Ready is also dropped during low phases only, which exposes a design that loses or repeats a half-step, or one that samples ready in the wrong phase. A long run without any clear checks the wrap from 15 to 0. Reset is held mid-instruction for several cycles. A random phase mixes stalls, clears and new opcodes, which catches an instruction register that loads outside step 1 or drifts afterwards.

// File: rtl/ustep_seq.sv
module ustep_seq #(
  parameter int CNT_W = 4,
  parameter int OP_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdy,
  input  logic             clr_step,
  input  logic [OP_W-1:0]  din,
  output logic [CNT_W:0]   step,
  output logic             ir_load,
  output logic             sync,
  output logic [OP_W-1:0]  ir
);

  logic             ph;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= 1'b0;
      cnt <= '0;
    end else if (!ph) begin
      ph <= 1'b1;
    end else if (rdy) begin
      ph  <= 1'b0;
      cnt <= clr_step ? '0 : cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ir <= '0;
    else if (ir_load) ir <= din;
  end

  assign sync    = (cnt == '0);
  assign ir_load = sync & ph;
  assign step    = {cnt, ph};

  p_low_to_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !step[0] |=> step[0] && (step[CNT_W:1] == $past(step[CNT_W:1])));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step[0] && rdy && !clr_step) |=> !step[0] && (step[CNT_W:1] == $past(step[CNT_W:1]) + CNT_W'(1)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step[0] && rdy && clr_step) |=> step == '0);

  p_reset_r5: assert property (@(posedge clk)
    !rst_n |=> (step == '0) && (ir == '0));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step[0] && !rdy) |=> $stable(step));

  p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> (step == (CNT_W+1)'(1)));

  p_ir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(ir));

  p_ir_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> ir == $past(din));

  p_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (step[CNT_W:1] == '0));

endmodule

// File: tb/test_ustep_seq.sv
`timescale 1ns/1ps
module test_ustep_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rdy = 1'b1;
  logic       clr_step = 1'b0;
  logic [7:0] din = 8'h00;
  logic [4:0] step;
  logic       ir_load, sync;
  logic [7:0] ir;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int         m_cnt = 0;
  bit         m_ph = 1'b0;
  logic [7:0] m_ir = 8'h00;
  string      tag = "R5";

  always #2.5 clk = ~clk;

  ustep_seq i_ustep_seq (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .clr_step(clr_step), .din(din),
    .step(step), .ir_load(ir_load), .sync(sync), .ir(ir)
  );

  function automatic logic [4:0] exp_step();
    return {m_cnt[3:0], m_ph};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 1'b0; m_ir = 8'h00; tag = "R5";
    end else begin
      if (m_cnt == 0 && m_ph) m_ir = din;
      if (!m_ph) begin
        m_ph = 1'b1;
        tag = clr_step ? "R4" : "R1";
      end else if (!rdy) begin
        tag = clr_step ? "R4" : "R6";
      end else begin
        m_ph = 1'b0;
        if (clr_step) begin m_cnt = 0; tag = "R3"; end
        else begin m_cnt = (m_cnt + 1) % 16; tag = "R2"; end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(bit r, bit c, logic [7:0] d, bit rn);
    @(negedge clk);
    check(tag, 32'(step), 32'(exp_step()));
    check("R9", 32'(sync), 32'(m_cnt == 0));
    check("R7", 32'(ir_load), 32'(m_cnt == 0 && m_ph));
    check("R8", 32'(ir), 32'(m_ir));
    rdy = r; clr_step = c; din = d; rst_n = rn;
  endtask

  task automatic run_instr(int len, logic [7:0] op);
    int guard = 0;
    while (guard < 200) begin
      bit c = (m_cnt == len - 1);
      bit last = c && m_ph;
      tick(1'b1, c, op, 1'b1);
      guard++;
      if (last) break;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0, 8'hA5, 1'b0);
    @(negedge clk);
    check("R5", 32'(step), 32'd0);
    check("R5", 32'(ir), 32'd0);
    rst_n = 1'b1;

    run_instr(2, 8'h11);
    run_instr(4, 8'h22);
    run_instr(7, 8'h33);
    run_instr(1, 8'h44);

    for (int n = 0; n < 3; n++) begin
      int len = (n == 0) ? 0 : (n == 1) ? 1 : 5;
      while (!(m_cnt == 1 && m_ph)) tick(1'b1, 1'b0, 8'h5A, 1'b1);
      for (int k = 0; k < len; k++) tick(1'b0, 1'b1, 8'h5A, 1'b1);
      tick(1'b1, 1'b0, 8'h5A, 1'b1);
      tick(1'b1, 1'b0, 8'h5A, 1'b1);
    end

    for (int k = 0; k < 20; k++) tick(m_ph, 1'b0, 8'h66, 1'b1);

    for (int k = 0; k < 40; k++) tick(1'b1, 1'b0, 8'h77, 1'b1);

    for (int k = 0; k < 4; k++) tick(1'b1, 1'b0, 8'h88, 1'b0);
    run_instr(3, 8'h99);

    for (int k = 0; k < 3000; k++)
      tick(($urandom % 4) != 0, ($urandom % 6) == 0, 8'($urandom), 1'b1);
    for (int k = 0; k < 50; k++)
      tick(1'b1, ($urandom % 3) == 0, 8'($urandom), ($urandom % 25) != 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule